// File: doc/BRIEF.md
# Serial Subcarrier Word Transmitter

This block sends the colour-subcarrier frequency control word and two status flags out of the chip, one bit per clock, on a single line. The word is a binary fraction: the subcarrier frequency equals the word divided by 2^23, times the bit clock. The bit clock runs at twice the pixel rate. Another block, such as a video encoder, can lock its own subcarrier to this stream.

Frames repeat for as long as enable is held high. Every frame lasts the same number of clocks. The word and the flags are captured once per frame, on the clock that emits the start bit. They then stay frozen until the frame ends. A one-clock strobe marks each start bit so that a receiver or a scope can align to it. When enable goes low, the frame in progress still finishes. After that the line rests low.

Top module: `sc_word_tx`

## Requirements
- R1: A synchronous reset drives `ser_out` and `frame_start` low on the next clock edge and abandons any frame in progress.
- R2: Slot 0 of every frame is the start bit: `ser_out` is high for exactly one clock, and `frame_start` is high in that same clock and in no other slot.
- R3: Slots 1 to WORD_W carry the frequency word with the most significant bit first. Slot k carries bit WORD_W−k.
- R4: Slot WORD_W+1 carries `rst_flag_n` exactly as captured (active low, 0 asks for a subcarrier reset). Slot WORD_W+2 carries `seq_flag` as captured (for PAL, 1 means the R−Y line is normal).
- R5: Every slot from WORD_W+3 up to FRAME_LEN−1 is reserved and drives `ser_out` low.
- R6: While `en` stays high, frames follow one another without a gap. Each start bit comes exactly FRAME_LEN clocks after the one before it.
- R7: The word and the flags are sampled only on the start-bit clock. Changes made during a frame appear only in the next frame.
- R8: While no frame is running and `en` is low, `ser_out` and `frame_start` stay low and no frame begins.
- R9: If `en` falls during a frame, that frame still completes all FRAME_LEN slots.
- R10: The first start bit appears on the first clock edge after reset is released, provided `en` is high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (twice the pixel rate) |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Allows new frames to start |
| freq_word | input | WORD_W | Subcarrier frequency control word |
| rst_flag_n | input | 1 | Subcarrier reset request, active low |
| seq_flag | input | 1 | Line-phase sequence flag |
| ser_out | output | 1 | Serial frame line |
| frame_start | output | 1 | One-clock strobe during the start bit |

## Verification
The bench builds the block with its defaults: a 23-bit word in a 128-clock frame. With these values both flag slots, the first reserved slot and the last reserved slot can all be reached, and so can the wrap from slot 127 straight back to a new start bit. Random words and flags are mixed with directed cases. The directed cases cover an all-ones word, an all-zeros word and a word with only its end bits set, plus every flag combination. They also cover input changes in the middle of a frame, enable falling during a frame and a reset in the middle of a frame.

// File: rtl/sc_word_tx_pkg.sv
package sc_word_tx_pkg;

    localparam int unsigned DEF_WORD_W    = 23;
    localparam int unsigned DEF_FRAME_LEN = 128;

    typedef enum logic [2:0] {
        SK_START,
        SK_WORD,
        SK_RSTN,
        SK_SEQ,
        SK_RSVD
    } slot_kind_e;

    typedef struct packed {
        logic rst_n;
        logic seq;
    } status_flags_t;

    function automatic slot_kind_e classify_slot(input int unsigned slot,
                                                 input int unsigned word_w);
        if (slot == 0)                return SK_START;
        else if (slot <= word_w)      return SK_WORD;
        else if (slot == word_w + 1)  return SK_RSTN;
        else if (slot == word_w + 2)  return SK_SEQ;
        else                          return SK_RSVD;
    endfunction

endpackage

// File: rtl/sc_slot_counter.sv
module sc_slot_counter #(
    parameter int unsigned FRAME_LEN = 128,
    localparam int unsigned SLOT_W   = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic              launch,
    output logic              advance,
    output logic [SLOT_W-1:0] next_slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);

    logic              busy;
    logic [SLOT_W-1:0] slot;
    logic              at_last;

    assign at_last   = (slot == LAST);
    assign launch    = en && (!busy || at_last);
    assign advance   = busy && !at_last;
    assign next_slot = launch ? '0 : SLOT_W'(slot + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            slot <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            slot <= '0;
        end else if (advance) begin
            slot <= SLOT_W'(slot + 1'b1);
        end else begin
            busy <= 1'b0;
            slot <= '0;
        end
    end

    // R6
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !at_last |=> slot == SLOT_W'($past(slot) + 1'b1));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en && (!busy || at_last) |=> !busy && slot == '0);

    // R9
    finish_frame_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !at_last && !en |=> busy);

endmodule

// File: rtl/sc_payload_latch.sv
module sc_payload_latch
    import sc_word_tx_pkg::*;
#(
    parameter int unsigned WORD_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  status_flags_t     flags_in,
    output logic [WORD_W-1:0] word_q,
    output status_flags_t     flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            flags_q <= '{rst_n: 1'b1, seq: 1'b0};
        end else if (load) begin
            word_q  <= word_in;
            flags_q <= flags_in;
        end
    end

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word_q) && $stable(flags_q));

endmodule

// File: rtl/sc_bit_select.sv
module sc_bit_select
    import sc_word_tx_pkg::*;
#(
    parameter int unsigned WORD_W = 23,
    parameter int unsigned SLOT_W = 7
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [WORD_W-1:0] word_q,
    input  status_flags_t     flags_q,
    output logic              bit_out
);
    logic [WORD_W-1:0] word_hit;

    // slot k (1..WORD_W) carries word bit WORD_W-k
    for (genvar g = 0; g < WORD_W; g++) begin : g_word
        assign word_hit[g] = (slot == SLOT_W'(WORD_W - g)) && word_q[g];
    end

    always_comb begin
        unique case (classify_slot(int'(slot), WORD_W))
            SK_START: bit_out = 1'b1;
            SK_WORD:  bit_out = |word_hit;
            SK_RSTN:  bit_out = flags_q.rst_n;
            SK_SEQ:   bit_out = flags_q.seq;
            default:  bit_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_word_tx.sv
module sc_word_tx
    import sc_word_tx_pkg::*;
#(
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned FRAME_LEN = DEF_FRAME_LEN,
    localparam int unsigned SLOT_W   = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] freq_word,
    input  logic              rst_flag_n,
    input  logic              seq_flag,
    output logic              ser_out,
    output logic              frame_start
);
    logic              launch;
    logic              advance;
    logic [SLOT_W-1:0] next_slot;
    logic [WORD_W-1:0] word_q;
    status_flags_t     flags_q;
    status_flags_t     flags_in;
    logic              slot_bit;

    assign flags_in = '{rst_n: rst_flag_n, seq: seq_flag};

    sc_slot_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .launch    (launch),
        .advance   (advance),
        .next_slot (next_slot)
    );

    sc_payload_latch #(.WORD_W(WORD_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .word_in  (freq_word),
        .flags_in (flags_in),
        .word_q   (word_q),
        .flags_q  (flags_q)
    );

    sc_bit_select #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_sel (
        .slot    (next_slot),
        .word_q  (word_q),
        .flags_q (flags_q),
        .bit_out (slot_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_out     <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            ser_out     <= (launch || advance) ? slot_bit : 1'b0;
            frame_start <= launch;
        end
    end

    // R2
    start_high_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> ser_out);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ser_out && !frame_start);

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

endmodule

// File: tb/sc_word_tx_tb_top.sv
module sc_word_tx_tb_top;
    localparam int W = 23;
    localparam int L = 128;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] freq_word = '0;
    logic         rst_flag_n = 1'b1;
    logic         seq_flag = 1'b0;
    logic         ser_out;
    logic         frame_start;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sc_word_tx #(.WORD_W(W), .FRAME_LEN(L)) dut_i (
        .clk(clk), .rst(rst), .en(en), .freq_word(freq_word),
        .rst_flag_n(rst_flag_n), .seq_flag(seq_flag),
        .ser_out(ser_out), .frame_start(frame_start)
    );

    function automatic logic exp_bit(int k, logic [W-1:0] w, logic r, logic s);
        if (k == 0) return 1'b1;
        if (k <= W) return w[W-k];
        if (k == W + 1) return r;
        if (k == W + 2) return s;
        return 1'b0;
    endfunction

    function automatic string slot_req(int k);
        if (k == 0) return "R2";
        if (k <= W) return "R3";
        if (k <= W + 2) return "R4";
        return "R5";
    endfunction

    task automatic chk(string req, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic scramble();
        freq_word  = W'($urandom);
        rst_flag_n = 1'($urandom);
        seq_flag   = 1'($urandom);
    endtask

    // Sets inputs at a negedge, then observes one full frame.
    // drop_at >= 0 lowers en at that slot (R9).
    task automatic run_frame(logic [W-1:0] w, logic r, logic s, string req0, int drop_at);
        freq_word = w; rst_flag_n = r; seq_flag = s;
        step();
        chk(req0, frame_start, 1'b1);
        chk("R2", ser_out, 1'b1);
        for (int k = 1; k < L; k++) begin
            if (k == 1) scramble();              // R7: mid-frame change ignored
            if (k == drop_at) en = 1'b0;         // R9
            step();
            chk(slot_req(k), ser_out, exp_bit(k, w, r, s));
            chk(drop_at >= 0 ? "R9" : "R2", frame_start, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd5147));
        step(); step();
        // R1: reset state
        chk("R1", ser_out, 1'b0);
        chk("R1", frame_start, 1'b0);

        // R10: first start on the first edge after release
        rst = 1'b0; en = 1'b1;
        run_frame(23'h7FFFFF, 1'b1, 1'b1, "R10", -1);
        // R6: back-to-back frames, directed patterns
        run_frame(23'h000000, 1'b0, 1'b0, "R6", -1);
        run_frame(23'h400001, 1'b0, 1'b1, "R6", -1);
        run_frame(23'h2AAAAA, 1'b1, 1'b0, "R6", -1);
        for (int i = 0; i < 6; i++)
            run_frame(W'($urandom), 1'($urandom), 1'($urandom), "R6", -1);

        // R9 then R8: enable drops mid-frame, frame completes, line idles
        run_frame(W'($urandom), 1'b1, 1'b0, "R6", 5);
        for (int i = 0; i < 20; i++) begin
            scramble();
            step();
            chk("R8", ser_out, 1'b0);
            chk("R8", frame_start, 1'b0);
        end

        // R7: restart after idle samples the values present at the start edge
        en = 1'b1;
        run_frame(23'h123456, 1'b0, 1'b1, "R7", -1);

        // R1: reset in mid-frame
        freq_word = 23'h7FFFFF; rst_flag_n = 1'b1; seq_flag = 1'b1;
        step();
        chk("R2", frame_start, 1'b1);
        repeat (10) step();
        rst = 1'b1;
        step();
        chk("R1", ser_out, 1'b0);
        chk("R1", frame_start, 1'b0);
        step();
        chk("R1", ser_out, 1'b0);
        rst = 1'b0;
        run_frame(W'($urandom), 1'($urandom), 1'($urandom), "R10", -1);

        // R10 with enable low at release: nothing starts until en rises
        rst = 1'b1; en = 1'b0;
        step();
        rst = 1'b0;
        repeat (3) begin
            step();
            chk("R8", frame_start, 1'b0);
            chk("R8", ser_out, 1'b0);
        end
        en = 1'b1;
        run_frame(23'h000001, 1'b1, 1'b0, "R10", -1);

        finish_up();
    end
endmodule